// File: doc/BRIEF.md
# Game Controller Poll Responder

This block answers as a serial peripheral on a four-wire SPI bus in the way a simple game controller does. A host opens a frame by pulling chip select low. It sends a poll command byte, then a read command byte, then filler bytes. The responder returns an identifier that names its mode, digital or analog, followed by button and axis bytes. A digital-mode frame carries four data bytes and an analog-mode frame carries eight. The serial pins are brought into the system clock domain through a synchronizer chain and both SCK edges are detected there, so SCK must be several times slower than the system clock.

Every reply byte is fixed before the byte it travels in begins, so the responder always runs one byte behind the host. It cannot answer a command during that same command byte, so the reply to the first byte is a fixed filler. Button, axis and mode inputs are captured once when chip select falls. Every byte of one poll therefore comes from the same instant.

Top module: `gcr_spi_responder`

## Requirements
- R1: While chip select (`spi_cs_n`, active low) is high, and after reset, `spi_miso` is held at 1.
- R2: The bus runs SPI mode 3 with 8-bit bytes and the least significant bit first. `spi_miso` changes only after a falling SCK edge, and both sides sample on the rising edge.
- R3: During the first byte of a frame, the command byte, the responder returns 0xFF.
- R4: If the first byte received is 0x01, the reply during the second byte is 0x41 when the mode captured at frame start is digital (`analog_mode`=0), and 0x73 when it is analog (`analog_mode`=1).
- R5: If the first two bytes are 0x01 and 0x42, the following bytes return 4 data bytes in digital mode and 8 in analog mode. Data byte k is byte k of the vector {axes, buttons}: byte 0 is buttons[7:0], byte 1 is buttons[15:8], and bytes 2 to 7 are axes[7:0] up to axes[47:40].
- R6: Once the data bytes are exhausted, every further byte of the frame returns 0xFF.
- R7: If the first byte is not 0x01, every later byte of the frame returns 0xFF. If the first byte is 0x01 and the second is not 0x42, every byte after the identifier returns 0xFF.
- R8: Buttons, axes and mode are captured when chip select falls. Changes to them during the frame have no effect on its replies.
- R9: Raising chip select at any point, including in the middle of a byte, abandons the frame. The next frame starts again at the command byte with a fresh bit count.
- R10: The values of the host's filler bytes after the read command have no effect on the replies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host, idle high |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Host-to-responder data |
| spi_miso | output | 1 | Responder-to-host data |
| analog_mode | input | 1 | 1 selects analog mode, 0 digital |
| buttons | input | 16 | Button states, two bytes |
| axes | input | 48 | Six 8-bit axis values, axis 0 in the low byte |

## Verification
The bench builds the block with its default parameters: four digital data bytes, eight analog data bytes, two button bytes and a two-stage synchronizer. With these values, frames of up to twelve bytes run past the end of the data in both modes, so the switch from data to filler is reached in both. The last axis byte and the data-count boundary are exercised in analog mode. Random frames mix valid and corrupted command bytes, random fillers and random lengths. Directed frames cover a mid-byte abort, a restart after the identifier, and input changes made after capture.

// File: rtl/gcr_pkg.sv
package gcr_pkg;

    localparam int unsigned BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CMD_POLL   = 8'h01;
    localparam logic [BYTE_W-1:0] CMD_READ   = 8'h42;
    localparam logic [BYTE_W-1:0] ID_DIGITAL = 8'h41;
    localparam logic [BYTE_W-1:0] ID_ANALOG  = 8'h73;
    localparam logic [BYTE_W-1:0] FILL_BYTE  = 8'hFF;

    // Synchronized view of the serial pins
    typedef struct packed {
        logic sck;
        logic cs_n;
        logic mosi;
    } spi_pins_t;

    // Bus at rest: clock high (mode 3), deselected, data high
    localparam spi_pins_t PINS_IDLE = '{sck: 1'b1, cs_n: 1'b1, mosi: 1'b1};

    // Position within a frame
    typedef enum logic [1:0] {
        FS_CMD  = 2'd0,   // waiting for the poll command
        FS_ID   = 2'd1,   // identifier loaded, waiting for the read command
        FS_DATA = 2'd2,   // streaming captured data
        FS_PAD  = 2'd3    // rejected or exhausted: filler only
    } frame_state_e;

    function automatic logic [BYTE_W-1:0] id_for_mode(input logic analog);
        return analog ? ID_ANALOG : ID_DIGITAL;
    endfunction

endpackage

// File: rtl/gcr_sync.sv
module gcr_sync
    import gcr_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  spi_pins_t din,
    output spi_pins_t dout
);

    spi_pins_t stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= PINS_IDLE;
        else     stg[0] <= din;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= PINS_IDLE;
                else     stg[g] <= stg[g-1];
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/gcr_bit_engine.sv
module gcr_bit_engine
    import gcr_pkg::*;
#(
    parameter int unsigned W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sck_s,
    input  logic         cs_n_s,
    input  logic         mosi_s,
    input  logic [W-1:0] tx_byte,
    output logic         byte_done,
    output logic [W-1:0] rx_byte,
    output logic         frame_start,
    output logic         frame_active,
    output logic         miso
);

    localparam int unsigned CNT_W = (W > 1) ? $clog2(W) : 1;

    logic             sck_d;
    logic             cs_n_d;
    logic [CNT_W-1:0] bit_cnt;
    logic [W-1:0]     rx_sh;
    logic             rise;
    logic             fall;

    assign frame_active = ~cs_n_s;
    assign frame_start  = cs_n_d & ~cs_n_s;
    assign rise         = ~sck_d & sck_s & ~cs_n_s;
    assign fall         = sck_d & ~sck_s & ~cs_n_s;
    assign rx_byte      = rx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d  <= 1'b1;
            cs_n_d <= 1'b1;
        end else begin
            sck_d  <= sck_s;
            cs_n_d <= cs_n_s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || cs_n_s) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            miso      <= 1'b1;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (rise) begin
                rx_sh <= {mosi_s, rx_sh[W-1:1]};   // LSB arrives first
                if (bit_cnt == CNT_W'(W-1)) begin
                    bit_cnt   <= '0;
                    byte_done <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + CNT_W'(1);
                end
            end
            if (fall) miso <= tx_byte[bit_cnt];
        end
    end

    // R1: deselected bus leaves the output high
    p_miso_idle_r1: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> miso);

    // R2: output only moves after a falling clock edge
    p_miso_only_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
        (!fall && !cs_n_s) |=> $stable(miso));

    // R2: a completed byte is a single-cycle event
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        byte_done |=> !byte_done);

endmodule

// File: rtl/gcr_sequencer.sv
module gcr_sequencer
    import gcr_pkg::*;
#(
    parameter int unsigned DIG_BYTES = 4,
    parameter int unsigned ANA_BYTES = 8,
    parameter int unsigned SNAP_W    = ANA_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              frame_active,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              analog_mode,
    input  logic [SNAP_W-1:0] snap_in,
    output logic [BYTE_W-1:0] tx_byte
);

    localparam int unsigned IDX_W = $clog2(ANA_BYTES + 1);
    localparam int unsigned SLOTS = 1 << IDX_W;

    frame_state_e      state;
    logic [IDX_W-1:0]  idx;
    logic [SNAP_W-1:0] snap;
    logic              mode_q;
    logic [IDX_W-1:0]  limit;
    logic [BYTE_W-1:0] slot [SLOTS];

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_slot
            if (g < ANA_BYTES) begin : g_data
                assign slot[g] = snap[g*BYTE_W +: BYTE_W];
            end else begin : g_pad
                assign slot[g] = FILL_BYTE;
            end
        end
    endgenerate

    assign limit = mode_q ? IDX_W'(ANA_BYTES) : IDX_W'(DIG_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            snap   <= '0;
            mode_q <= 1'b0;
        end else if (frame_start) begin
            snap   <= snap_in;
            mode_q <= analog_mode;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !frame_active || frame_start) begin
            state   <= FS_CMD;
            idx     <= '0;
            tx_byte <= FILL_BYTE;
        end else if (byte_done) begin
            unique case (state)
                FS_CMD: begin
                    if (rx_byte == CMD_POLL) begin
                        state   <= FS_ID;
                        tx_byte <= id_for_mode(mode_q);
                    end else begin
                        state   <= FS_PAD;
                        tx_byte <= FILL_BYTE;
                    end
                end
                FS_ID: begin
                    if (rx_byte == CMD_READ) begin
                        state   <= FS_DATA;
                        tx_byte <= slot[0];
                        idx     <= IDX_W'(1);
                    end else begin
                        state   <= FS_PAD;
                        tx_byte <= FILL_BYTE;
                    end
                end
                FS_DATA: begin
                    if (idx < limit) begin
                        tx_byte <= slot[idx];
                        idx     <= idx + IDX_W'(1);
                    end else begin
                        state   <= FS_PAD;
                        tx_byte <= FILL_BYTE;
                    end
                end
                default: tx_byte <= FILL_BYTE;
            endcase
        end
    end

    // R9: leaving the frame always returns to the command position
    p_restart_r9: assert property (@(posedge clk) disable iff (rst)
        !frame_active |=> (state == FS_CMD) && (tx_byte == FILL_BYTE));

    // R4: a poll command loads the identifier for the captured mode
    p_id_r4: assert property (@(posedge clk) disable iff (rst)
        (frame_active && !frame_start && byte_done && state == FS_CMD
         && rx_byte == CMD_POLL)
        |=> tx_byte == (mode_q ? ID_ANALOG : ID_DIGITAL));

    // R7: a wrong first command locks the frame into filler
    p_reject_r7: assert property (@(posedge clk) disable iff (rst)
        (frame_active && !frame_start && byte_done && state == FS_CMD
         && rx_byte != CMD_POLL) |=> state == FS_PAD);

    // R6: filler state never produces anything but 0xFF
    p_pad_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (state == FS_PAD && frame_active) |=> tx_byte == FILL_BYTE);

    // R5: the data index never passes the analog byte count
    p_idx_bound_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> idx <= IDX_W'(ANA_BYTES));

    // R8: captured values hold for the whole frame
    p_snap_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(snap) && $stable(mode_q));

endmodule

// File: rtl/gcr_spi_responder.sv
module gcr_spi_responder
    import gcr_pkg::*;
#(
    parameter int unsigned DIG_BYTES   = 4,
    parameter int unsigned ANA_BYTES   = 8,
    parameter int unsigned BTN_BYTES   = 2,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned AXIS_BYTES = ANA_BYTES - BTN_BYTES,
    localparam int unsigned SNAP_W     = ANA_BYTES * BYTE_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           spi_sck,
    input  logic                           spi_cs_n,
    input  logic                           spi_mosi,
    output logic                           spi_miso,
    input  logic                           analog_mode,
    input  logic [BTN_BYTES*BYTE_W-1:0]    buttons,
    input  logic [AXIS_BYTES*BYTE_W-1:0]   axes
);

    spi_pins_t         raw_pins;
    spi_pins_t         sync_pins;
    logic [BYTE_W-1:0] tx_byte;
    logic [BYTE_W-1:0] rx_byte;
    logic              byte_done;
    logic              frame_start;
    logic              frame_active;
    logic [SNAP_W-1:0] snap_in;

    assign raw_pins.sck  = spi_sck;
    assign raw_pins.cs_n = spi_cs_n;
    assign raw_pins.mosi = spi_mosi;
    assign snap_in       = {axes, buttons};

    gcr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_pins),
        .dout (sync_pins)
    );

    gcr_bit_engine #(.W(BYTE_W)) u_engine (
        .clk          (clk),
        .rst          (rst),
        .sck_s        (sync_pins.sck),
        .cs_n_s       (sync_pins.cs_n),
        .mosi_s       (sync_pins.mosi),
        .tx_byte      (tx_byte),
        .byte_done    (byte_done),
        .rx_byte      (rx_byte),
        .frame_start  (frame_start),
        .frame_active (frame_active),
        .miso         (spi_miso)
    );

    gcr_sequencer #(
        .DIG_BYTES (DIG_BYTES),
        .ANA_BYTES (ANA_BYTES),
        .SNAP_W    (SNAP_W)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .frame_start  (frame_start),
        .frame_active (frame_active),
        .byte_done    (byte_done),
        .rx_byte      (rx_byte),
        .analog_mode  (analog_mode),
        .snap_in      (snap_in),
        .tx_byte      (tx_byte)
    );

    // R3: a frame that has just opened offers filler for the command byte
    p_cmd_fill_r3: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> tx_byte == FILL_BYTE);

endmodule

// File: tb/tb_gcr_spi_responder.sv
module tb_gcr_spi_responder;

    localparam int H = 8;      // clocks per SCK half period
    localparam int MAXB = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spi_sck = 1'b1;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b1;
    logic        spi_miso;
    logic        analog_mode = 1'b0;
    logic [15:0] buttons = '0;
    logic [47:0] axes = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [7:0] sent [MAXB];
    logic [7:0] got;

    always #10 clk = ~clk;   // 50 MHz

    gcr_spi_responder dut (
        .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .analog_mode(analog_mode),
        .buttons(buttons), .axes(axes)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_reply(input int p, input logic [7:0] b0,
                                             input logic [7:0] b1, input logic mode,
                                             input logic [63:0] snap);
        int cnt;
        cnt = mode ? 8 : 4;
        if (p == 0) return 8'hFF;
        if (p == 1) return (b0 == 8'h01) ? (mode ? 8'h73 : 8'h41) : 8'hFF;
        if (b0 != 8'h01 || b1 != 8'h42) return 8'hFF;
        if (p - 2 < cnt) return snap[(p-2)*8 +: 8];
        return 8'hFF;
    endfunction

    task automatic xfer_bits(input logic [7:0] mo, input int nbits, output logic [7:0] mi);
        mi = 8'hFF;
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            spi_sck  = 1'b0;
            spi_mosi = mo[i];
            repeat (H) @(negedge clk);
            mi[i]   = spi_miso;
            spi_sck = 1'b1;
            repeat (H - 1) @(negedge clk);
        end
    endtask

    task automatic open_frame();
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic close_frame();
        repeat (4) @(negedge clk);
        spi_cs_n = 1'b1;
        spi_mosi = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    // Runs a whole frame of n bytes from sent[] and checks every reply
    task automatic run_frame(input int n, input logic mode, input logic [63:0] snap,
                             input string req, input bit change_inputs);
        logic [7:0] r;
        open_frame();
        if (change_inputs) begin
            buttons     = ~buttons;
            axes        = ~axes;
            analog_mode = ~analog_mode;
        end
        for (int p = 0; p < n; p++) begin
            xfer_bits(sent[p], 8, r);
            check($sformatf("%s byte%0d", req, p), r,
                  exp_reply(p, sent[0], sent[1], mode, snap));
        end
        close_frame();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] snap;
        logic        m;
        int          n;
        void'($urandom(32'h5EED1234));

        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 reset idle", {7'd0, spi_miso}, 8'h01);

        // R3 R4 R5 R6 R2: digital poll running past the data
        buttons = 16'hA51C; axes = 48'h665544332211; analog_mode = 1'b0;
        snap = {axes, buttons};
        sent[0] = 8'h01; sent[1] = 8'h42;
        for (int i = 2; i < MAXB; i++) sent[i] = 8'hFF;
        run_frame(8, 1'b0, snap, "R2_R3_R4_R5_R6 digital", 1'b0);
        check("R1 idle after frame", {7'd0, spi_miso}, 8'h01);

        // R5 R6: analog poll to the last axis and beyond
        analog_mode = 1'b1; buttons = 16'h3C81; axes = 48'hF0E1D2C3B4A5;
        snap = {axes, buttons};
        run_frame(12, 1'b1, snap, "R4_R5_R6 analog", 1'b0);

        // R7: wrong first command
        sent[0] = 8'h03; sent[1] = 8'h42;
        run_frame(6, 1'b1, snap, "R7 bad first", 1'b0);
        // R7: wrong second command
        sent[0] = 8'h01; sent[1] = 8'h40;
        analog_mode = 1'b0; snap = {axes, buttons};
        run_frame(6, 1'b0, snap, "R7 bad second", 1'b0);

        // R10: zero and patterned fillers
        sent[1] = 8'h42;
        for (int i = 2; i < MAXB; i++) sent[i] = (i % 2) ? 8'h00 : 8'h5A;
        run_frame(7, 1'b0, snap, "R10 fillers", 1'b0);

        // R8: inputs flip right after capture
        buttons = 16'h1234; axes = 48'hABCDEF012345; analog_mode = 1'b1;
        snap = {axes, buttons};
        for (int i = 2; i < MAXB; i++) sent[i] = 8'hFF;
        run_frame(11, 1'b1, snap, "R8 snapshot", 1'b1);

        // R9: abort in the middle of the command byte
        buttons = 16'h0F0F; axes = 48'h0; analog_mode = 1'b0;
        snap = {axes, buttons};
        open_frame();
        xfer_bits(8'h01, 4, got);
        close_frame();
        check("R9 idle after abort", {7'd0, spi_miso}, 8'h01);
        run_frame(6, 1'b0, snap, "R9 after mid-byte abort", 1'b0);

        // R9: abort right after the identifier byte
        open_frame();
        xfer_bits(8'h01, 8, got);
        xfer_bits(8'h42, 8, got);
        check("R9 id before abort", got, 8'h41);
        close_frame();
        run_frame(4, 1'b0, snap, "R9 after frame abort", 1'b0);

        // Random frames
        for (int f = 0; f < 40; f++) begin
            m = 1'($urandom_range(0, 1));
            analog_mode = m;
            buttons = 16'($urandom);
            axes = {16'($urandom), 32'($urandom)};
            snap = {axes, buttons};
            sent[0] = ($urandom_range(0, 9) < 8) ? 8'h01 : 8'($urandom);
            sent[1] = ($urandom_range(0, 9) < 8) ? 8'h42 : 8'($urandom);
            for (int i = 2; i < MAXB; i++) sent[i] = 8'($urandom);
            n = $urandom_range(2, MAXB);
            run_frame(n, m, snap, "R5_R6_R7_R10 random", 1'b0);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule